// File: doc/BRIEF.md
# Bridge-Tied-Load Class-D Leg Controller

This block is the digital control core of a two-channel bridge-tied-load class-D switching stage. Each channel takes a 1-bit pulse-width or pulse-density audio stream and drives a positive and a negative half-bridge leg. Every leg is controlled by a pair of gate enables, one for the high-side switch and one for the low-side switch. A leg can therefore drive high, drive low or float. Level shifting, the power FETs, output filtering and supply regulation sit outside this block.

A select input chooses how audio is captured. In clocked mode each data bit is registered on the rising edge of the master clock. In unclocked mode the data goes straight to the legs. The active-low halt and active-low standby inputs are each synchronised through two master-clock flops and then combined with the data in a fixed priority. Halt pulls every leg low. Standby, when halt is not active, floats every leg. Otherwise the data bit sets the bridge polarity. In clocked mode, a change of a leg between high and low passes through a programmable dead gap of 0 to 3 clock cycles with both enables off. A separate beep input is passed to a differential pair of outputs whatever the control inputs are doing.

Top module: `btl_drive_ctrl`

## Requirements
- R1: With `sync_sel`=1, a `din` value present at rising edge e is captured there and reaches the leg enables after edge e+1. Between edges the legs do not follow `din`.
- R2: With `sync_sel`=0, the legs follow `din` combinationally, with no clock edge needed.
- R3: When the synchronised halt is low, every leg is pulled low whatever standby does. No high-side enable is set. The low-side enable rises immediately from a floating leg, or after the dead gap from a high leg in clocked mode.
- R4: When the synchronised halt is high and the synchronised standby is low, all four enables are 0 (all legs float).
- R5: In normal operation a data bit of 0 makes the channel's positive leg low (lo_en=1) and its negative leg high (hi_en=1).
- R6: In normal operation a data bit of 1 makes the positive leg high and the negative leg low.
- R7: Bit index 0 of `din` and of every leg bus is the left channel, and index 1 is the right channel.
- R8: `beep_out_p` equals `beep_in` and `beep_out_n` equals its complement at all times, including reset, halt and standby.
- R9: No leg ever has its high and low enables set together.
- R10: In clocked mode, when a leg must switch directly between high and low, it spends exactly `gap_sel` cycles (0 to 3) with both enables off. In unclocked mode the gap is zero.
- R11: `halt_n` and `stby_n` pass through a two-flop synchroniser. A level sampled at edge e is decoded after edge e+1, so it shows after edge e+1 in unclocked mode and after edge e+2 in clocked mode.
- R12: While `rst_n` is low, every leg is held low (all lo_en=1, all hi_en=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_sel | input | 1 | 1: clocked data capture, 0: unclocked |
| halt_n | input | 1 | Active-low halt, pulls all legs low |
| stby_n | input | 1 | Active-low standby, floats all legs |
| gap_sel | input | GAP_W | Dead gap length in clocks (clocked mode) |
| din | input | N_CH | 1-bit audio per channel (0 left, 1 right) |
| beep_in | input | 1 | Beep tone input |
| pos_hi_en | output | N_CH | Positive leg high-side enable |
| pos_lo_en | output | N_CH | Positive leg low-side enable |
| neg_hi_en | output | N_CH | Negative leg high-side enable |
| neg_lo_en | output | N_CH | Negative leg low-side enable |
| beep_out_p | output | 1 | Beep, true polarity |
| beep_out_n | output | 1 | Beep, inverted polarity |

## Verification
The bench concentrates on polarity reversals under each gap setting. A design that counts the dead gap wrongly shows one floating cycle too many or too few. A design that skips the gap would momentarily hand a leg from low-side to high-side with no floating cycle between. Halt asserted together with standby is driven to catch a swapped priority, which would float the bridge instead of grounding it. Unclocked mode is checked between clock edges, so a design that still registers data shows the old polarity there. Every cycle is compared against a model, so a synchroniser with the wrong depth shows up as a shifted halt or standby response.

// File: rtl/btl_pkg.sv
package btl_pkg;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_t;

    // Priority: halt grounds the bridge, then standby floats it, then data picks polarity.
    function automatic leg_t leg_target(input logic run_ok, input logic awake,
                                        input logic bit_v, input logic invert);
        if (!run_ok)
            return LEG_LO;
        else if (!awake)
            return LEG_OFF;
        else
            return (bit_v ^ invert) ? LEG_HI : LEG_LO;
    endfunction

    function automatic logic is_reversal(input leg_t from_s, input leg_t to_s);
        return ((from_s == LEG_HI) && (to_s == LEG_LO)) ||
               ((from_s == LEG_LO) && (to_s == LEG_HI));
    endfunction

endpackage

// File: rtl/btl_ctl_sync.sv
module btl_ctl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.stg[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            r_d.stg[k] = r_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_out = r_q.stg[STAGES-1];

endmodule

// File: rtl/btl_leg_bbm.sv
module btl_leg_bbm
    import btl_pkg::*;
#(
    parameter int GAP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_sel,
    input  logic [GAP_W-1:0] gap_sel,
    input  leg_t             target,
    output logic             hi_en,
    output logic             lo_en
);

    typedef struct packed {
        leg_t             drv;
        logic [GAP_W-1:0] cnt;
    } leg_regs_t;

    leg_regs_t r_d, r_q;
    leg_t      shown;

    always_comb begin
        r_d = r_q;
        if (!sync_sel) begin
            r_d.drv = target;
            r_d.cnt = '0;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - GAP_W'(1);
            r_d.drv = (r_q.cnt == GAP_W'(1)) ? target : LEG_OFF;
        end else if (is_reversal(r_q.drv, target)) begin
            if (gap_sel == '0) begin
                r_d.drv = target;
            end else begin
                r_d.drv = LEG_OFF;
                r_d.cnt = gap_sel;
            end
        end else begin
            r_d.drv = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.drv <= LEG_LO;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign shown = sync_sel ? r_q.drv : target;
    assign hi_en = (shown == LEG_HI);
    assign lo_en = (shown == LEG_LO);

endmodule

// File: rtl/btl_drive_ctrl.sv
module btl_drive_ctrl
    import btl_pkg::*;
#(
    parameter int N_CH  = 2,
    parameter int GAP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_sel,
    input  logic             halt_n,
    input  logic             stby_n,
    input  logic [GAP_W-1:0] gap_sel,
    input  logic [N_CH-1:0]  din,
    input  logic             beep_in,
    output logic [N_CH-1:0]  pos_hi_en,
    output logic [N_CH-1:0]  pos_lo_en,
    output logic [N_CH-1:0]  neg_hi_en,
    output logic [N_CH-1:0]  neg_lo_en,
    output logic             beep_out_p,
    output logic             beep_out_n
);

    localparam int CTL_W = 2;

    typedef struct packed {
        logic [N_CH-1:0] data;
    } cap_regs_t;

    cap_regs_t       cap_d, cap_q;
    logic [CTL_W-1:0] ctl_s;
    logic            run_ok;
    logic            awake;

    btl_ctl_sync #(.W(CTL_W), .STAGES(2)) u_ctl_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({halt_n, stby_n}),
        .sync_out (ctl_s)
    );

    assign run_ok = ctl_s[1];
    assign awake  = ctl_s[0];

    always_comb begin
        cap_d      = cap_q;
        cap_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic bit_sel;
        leg_t pos_tgt;
        leg_t neg_tgt;

        assign bit_sel = sync_sel ? cap_q.data[ch] : din[ch];
        assign pos_tgt = leg_target(run_ok, awake, bit_sel, 1'b0);
        assign neg_tgt = leg_target(run_ok, awake, bit_sel, 1'b1);

        btl_leg_bbm #(.GAP_W(GAP_W)) u_pos (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_sel (sync_sel),
            .gap_sel  (gap_sel),
            .target   (pos_tgt),
            .hi_en    (pos_hi_en[ch]),
            .lo_en    (pos_lo_en[ch])
        );

        btl_leg_bbm #(.GAP_W(GAP_W)) u_neg (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_sel (sync_sel),
            .gap_sel  (gap_sel),
            .target   (neg_tgt),
            .hi_en    (neg_hi_en[ch]),
            .lo_en    (neg_lo_en[ch])
        );
    end

    assign beep_out_p = beep_in;
    assign beep_out_n = ~beep_in;

endmodule

// File: rtl/btl_drive_ctrl_chk.sv
module btl_drive_ctrl_chk #(
    parameter int N_CH  = 2,
    parameter int GAP_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_sel,
    input logic             halt_n,
    input logic             stby_n,
    input logic [GAP_W-1:0] gap_sel,
    input logic             beep_in,
    input logic [N_CH-1:0]  pos_hi_en,
    input logic [N_CH-1:0]  pos_lo_en,
    input logic [N_CH-1:0]  neg_hi_en,
    input logic [N_CH-1:0]  neg_lo_en,
    input logic             beep_out_p,
    input logic             beep_out_n
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R8
    beep_diff_chk: assert property (@(posedge clk)
        (beep_out_p == beep_in) && (beep_out_n != beep_out_p));

    for (genvar i = 0; i < N_CH; i++) begin : g_leg_chk
        // R9
        leg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pos_hi_en[i] && pos_lo_en[i]) && !(neg_hi_en[i] && neg_lo_en[i]));

        // R3
        halt_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3) && !$past(halt_n, 1) && !$past(halt_n, 2) && !$past(halt_n, 3)
            |-> !pos_hi_en[i] && !neg_hi_en[i]);

        // R4
        stby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3) && $past(halt_n, 1) && $past(halt_n, 2) && $past(halt_n, 3)
            && !$past(stby_n, 1) && !$past(stby_n, 2) && !$past(stby_n, 3)
            |-> !pos_hi_en[i] && !pos_lo_en[i] && !neg_hi_en[i] && !neg_lo_en[i]);

        // R10
        gap_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3) && sync_sel && $past(sync_sel) && ($past(gap_sel) != '0)
            && $past(pos_lo_en[i]) |-> !pos_hi_en[i]);
    end

endmodule

bind btl_drive_ctrl btl_drive_ctrl_chk #(.N_CH(N_CH), .GAP_W(GAP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_sel   (sync_sel),
    .halt_n     (halt_n),
    .stby_n     (stby_n),
    .gap_sel    (gap_sel),
    .beep_in    (beep_in),
    .pos_hi_en  (pos_hi_en),
    .pos_lo_en  (pos_lo_en),
    .neg_hi_en  (neg_hi_en),
    .neg_lo_en  (neg_lo_en),
    .beep_out_p (beep_out_p),
    .beep_out_n (beep_out_n)
);

// File: tb/btl_drive_ctrl_bench.sv
`timescale 1ns/1ps
module btl_drive_ctrl_bench;

    localparam int N_CH = 2;
    localparam int GAP_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_sel = 1'b1;
    logic             halt_n = 1'b1;
    logic             stby_n = 1'b1;
    logic [GAP_W-1:0] gap_sel = '0;
    logic [N_CH-1:0]  din = '0;
    logic             beep_in = 1'b0;
    logic [N_CH-1:0]  pos_hi_en, pos_lo_en, neg_hi_en, neg_lo_en;
    logic             beep_out_p, beep_out_n;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R12";

    // Reference state: leg codes 0 float, 1 high, 2 low; leg 2*ch positive, 2*ch+1 negative.
    int m_h1 = 0, m_h2 = 0, m_s1 = 0, m_s2 = 0;
    int m_dq [N_CH];
    int m_drv[2*N_CH];
    int m_cnt[2*N_CH];

    btl_drive_ctrl #(.N_CH(N_CH), .GAP_W(GAP_W)) u_btl_drive_ctrl (
        .clk(clk), .rst_n(rst_n), .sync_sel(sync_sel), .halt_n(halt_n),
        .stby_n(stby_n), .gap_sel(gap_sel), .din(din), .beep_in(beep_in),
        .pos_hi_en(pos_hi_en), .pos_lo_en(pos_lo_en),
        .neg_hi_en(neg_hi_en), .neg_lo_en(neg_lo_en),
        .beep_out_p(beep_out_p), .beep_out_n(beep_out_n)
    );

    always #10 clk = ~clk;

    function automatic int want(int leg, int bitv);
        if (m_h2 == 0) return 2;
        if (m_s2 == 0) return 0;
        if (leg % 2 == 0) return (bitv != 0) ? 1 : 2;
        return (bitv != 0) ? 2 : 1;
    endfunction

    function automatic int exp_leg(int leg);
        if (!sync_sel) return want(leg, int'(din[leg/2]));
        return m_drv[leg];
    endfunction

    task automatic model_reset();
        m_h1 = 0; m_h2 = 0; m_s1 = 0; m_s2 = 0;
        for (int c = 0; c < N_CH; c++) m_dq[c] = 0;
        for (int l = 0; l < 2*N_CH; l++) begin m_drv[l] = 2; m_cnt[l] = 0; end
    endtask

    task automatic model_edge();
        int nd[2*N_CH];
        int nc[2*N_CH];
        for (int l = 0; l < 2*N_CH; l++) begin
            int t;
            t = want(l, sync_sel ? m_dq[l/2] : int'(din[l/2]));
            nd[l] = t; nc[l] = 0;
            if (sync_sel) begin
                if (m_cnt[l] > 0) begin
                    nc[l] = m_cnt[l] - 1;
                    nd[l] = (m_cnt[l] == 1) ? t : 0;
                end else if (((m_drv[l] == 1) && (t == 2)) || ((m_drv[l] == 2) && (t == 1))) begin
                    if (gap_sel != 0) begin nd[l] = 0; nc[l] = int'(gap_sel); end
                end
            end
        end
        for (int l = 0; l < 2*N_CH; l++) begin m_drv[l] = nd[l]; m_cnt[l] = nc[l]; end
        for (int c = 0; c < N_CH; c++) m_dq[c] = int'(din[c]);
        m_h2 = m_h1; m_h1 = int'(halt_n);
        m_s2 = m_s1; m_s1 = int'(stby_n);
    endtask

    task automatic check_all();
        logic [4*N_CH-1:0] act, exp;
        logic [N_CH-1:0] eph, epl, enh, enl;
        for (int c = 0; c < N_CH; c++) begin
            eph[c] = (exp_leg(2*c) == 1);
            epl[c] = (exp_leg(2*c) == 2);
            enh[c] = (exp_leg(2*c+1) == 1);
            enl[c] = (exp_leg(2*c+1) == 2);
        end
        act = {pos_hi_en, pos_lo_en, neg_hi_en, neg_lo_en};
        exp = {eph, epl, enh, enl};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s legs {ph,pl,nh,nl}: actual=%b expected=%b", tag, act, exp);
        end
        checks++;
        if (((pos_hi_en & pos_lo_en) | (neg_hi_en & neg_lo_en)) != '0) begin
            errors++;
            $display("FAIL R9 overlap: actual=%b expected=%b",
                     (pos_hi_en & pos_lo_en) | (neg_hi_en & neg_lo_en), {N_CH{1'b0}});
        end
        checks++;
        if ({beep_out_p, beep_out_n} !== {beep_in, ~beep_in}) begin
            errors++;
            $display("FAIL R8 beep: actual=%b expected=%b", {beep_out_p, beep_out_n}, {beep_in, ~beep_in});
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        if (!rst_n) model_reset();
        else        model_edge();
        @(negedge clk);
        #1;
        check_all();
    endtask

    // Drives new data after a cycle; in unclocked mode checks again before the next edge (R2).
    task automatic run(int n, int mode);
        for (int k = 0; k < n; k++) begin
            cycle();
            beep_in = 1'($urandom);
            if (mode == 0)      din = N_CH'($urandom);
            else if (mode == 1) din = ((k / 6) % 2 == 0) ? '0 : '1;
            else if (mode == 2) din = ((k / 5) % 2 == 0) ? 2'b10 : 2'b01;
            #1;
            if (!sync_sel) check_all();
        end
    endtask

    initial begin
        model_reset();
        tag = "R12";
        run(4, 3);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R11";
        run(4, 3);
        // R5, R6, R7: left bit 0, right bit 1 then swapped
        tag = "R5 R6 R7";
        run(20, 2);
        tag = "R1";
        run(40, 0);
        for (int g = 1; g < 4; g++) begin
            gap_sel = GAP_W'(g);
            tag = "R10";
            run(30, 1);
            run(20, 0);
        end
        tag = "R3";
        halt_n = 1'b0;
        run(15, 1);
        stby_n = 1'b0;
        run(15, 0);
        tag = "R4";
        halt_n = 1'b1;
        run(15, 0);
        tag = "R11";
        stby_n = 1'b1;
        run(10, 0);
        tag = "R2";
        sync_sel = 1'b0;
        run(40, 0);
        tag = "R3";
        halt_n = 1'b0;
        run(8, 0);
        halt_n = 1'b1;
        stby_n = 1'b0;
        tag = "R4";
        run(8, 0);
        stby_n = 1'b1;
        tag = "R10";
        run(20, 1);
        tag = "R1";
        sync_sel = 1'b1;
        gap_sel = 2'd2;
        run(30, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule